// File: doc/BRIEF.md
# DMA Channel Run/Hold/Kill Control Register

This block is the single control word through which software starts, holds, stops and kills the channels of a multi-channel DMA engine (up to eight channels). Each channel owns three control bits (run, hold and kill). Each of the three fields has a companion mask field, so one write can change any subset of channels. Software never has to read, merge and write back the word to touch one channel.

The register drives one run, hold and kill line per channel towards the channel engines. It also drives a stop-request line that is raised while a disable is pending. The engines report back with three pulse inputs: "finished", "parked" (the channel has come to rest after a hold) and "kill acknowledged". The block uses these to clear its own bits, so that a read of the word always shows whether a channel is truly running. A read showing run set means active. Run clear with hold set means suspended. Both clear means idle.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every run, hold, kill and stop-request bit is 0, and a read of the register returns 0.
- R2: The run bit of channel n (word bit n) changes only when mask bit 8+n is 1 in the same write. Writing run 1 with its mask set starts the channel. Writes with the mask bit at 0 leave run unchanged.
- R3: The hold bit of channel n (bit 16+n, mask bit 24+n) takes the written value when its mask bit is set. Writing 0 with the mask set is a resume. The hold output follows the bit.
- R4: The kill bit of channel n (bit 32+n, mask bit 40+n) is set by a masked write of 1. When the kill-acknowledged input of that channel is high at a clock edge, both kill and run read 0 from the next cycle on.
- R5: A masked write of run 0 to a running channel does not clear run. It raises that channel's stop-request output instead. Run and stop-request both clear after an edge at which the channel reports parked or finished. The same write to an idle channel has no effect. A masked write of run 1 withdraws a pending stop request.
- R6: When the finished input of a running channel is high at a clock edge, its run bit reads 0 from the next cycle on.
- R7: Mask positions (bits 8..15, 24..31, 40..47) and bits 48 and above always read 0. A read at any address other than the register address returns 0, and a write there changes nothing.
- R8: With NUM_CH below eight, the bits of channels NUM_CH..7 read 0 and ignore writes.
- R9: Read data is registered. It appears on the read-data port in the cycle after the read strobe, and it holds until the next read.
- R10: A finished or kill-acknowledged input at a clock edge overrides a software write of run (or kill) to 1 at the same edge.
- R11: A write affects only the channels whose mask bits are set. All other channels keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data with masks |
| reg_rdata | output | DATA_W | Registered read data |
| eng_done | input | NUM_CH | Per-channel finished pulse |
| eng_parked | input | NUM_CH | Per-channel parked (at rest) pulse |
| eng_kill_ack | input | NUM_CH | Per-channel kill-acknowledged pulse |
| chan_run | output | NUM_CH | Run bit per channel |
| chan_hold | output | NUM_CH | Hold bit per channel |
| chan_kill | output | NUM_CH | Kill bit per channel |
| chan_stop_req | output | NUM_CH | Pending disable per channel |

## Verification
Every state change is made at the clock edge that samples the write strobe or the engine pulse. The outputs and the stored word therefore show the new value one cycle later. A read adds one further edge before the word reaches the read-data port. The bench drives strobes and pulses on the falling edge so that exactly one rising edge sees them. It then samples outputs on the following falling edge, and it samples read data on the falling edge after the read strobe's rising edge. To show that a bit stays set up to the clearing edge, the kill and run outputs are also sampled while the acknowledge pulse is still high.

// File: rtl/dma_chan_ctl_pkg.sv
`timescale 1ns/1ps
package dma_chan_ctl_pkg;

   // Channel slots per field; field positions are fixed by software layout
   localparam int unsigned SLOTS       = 8;
   localparam int unsigned RUN_LSB     = 0;
   localparam int unsigned RUN_MSK_LSB = RUN_LSB + SLOTS;
   localparam int unsigned HLD_LSB     = RUN_MSK_LSB + SLOTS;
   localparam int unsigned HLD_MSK_LSB = HLD_LSB + SLOTS;
   localparam int unsigned KIL_LSB     = HLD_MSK_LSB + SLOTS;
   localparam int unsigned KIL_MSK_LSB = KIL_LSB + SLOTS;
   localparam int unsigned USED_BITS   = KIL_MSK_LSB + SLOTS;

   // Per-channel write request decoded from one register write
   typedef struct packed {
      logic run_we;
      logic run_val;
      logic hld_we;
      logic hld_val;
      logic kil_we;
      logic kil_val;
   } chan_wr_t;

   // Per-channel state
   typedef struct packed {
      logic run;
      logic hld;
      logic kil;
      logic stop;
   } chan_st_t;

endpackage

// File: rtl/dma_chan_ctl_decode.sv
`timescale 1ns/1ps
module dma_chan_ctl_decode
   import dma_chan_ctl_pkg::*;
#(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 64,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              rd_hit,
   output logic              rd_miss,
   output chan_wr_t          wr_req [NUM_CH]
);

   logic hit;
   logic wr_hit;
   logic unused_wdata;

   assign hit     = (reg_addr == REG_ADDR);
   assign wr_hit  = reg_wr & hit;
   assign rd_hit  = reg_rd & hit;
   assign rd_miss = reg_rd & ~hit;

   // upper and out-of-range bits carry no meaning
   assign unused_wdata = ^reg_wdata;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign wr_req[c].run_we  = wr_hit & reg_wdata[RUN_MSK_LSB + c];
      assign wr_req[c].run_val = reg_wdata[RUN_LSB + c];
      assign wr_req[c].hld_we  = wr_hit & reg_wdata[HLD_MSK_LSB + c];
      assign wr_req[c].hld_val = reg_wdata[HLD_LSB + c];
      assign wr_req[c].kil_we  = wr_hit & reg_wdata[KIL_MSK_LSB + c];
      assign wr_req[c].kil_val = reg_wdata[KIL_LSB + c];
   end

endmodule

// File: rtl/dma_chan_ctl_slice.sv
`timescale 1ns/1ps
module dma_chan_ctl_slice
   import dma_chan_ctl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  chan_wr_t wr,
   input  logic     done,
   input  logic     parked,
   input  logic     kill_ack,
   output chan_st_t st
);

   chan_st_t st_q;
   chan_st_t st_d;
   logic     clr_run;

   // hardware events that end a channel's activity
   assign clr_run = done | kill_ack | (st_q.stop & parked);

   always_comb begin
      st_d = st_q;
      if (clr_run) begin
         st_d.run  = 1'b0;
         st_d.stop = 1'b0;
      end else if (wr.run_we) begin
         if (wr.run_val) begin
            st_d.run  = 1'b1;
            st_d.stop = 1'b0;
         end else begin
            st_d.stop = st_q.run;
         end
      end
      if (wr.hld_we) begin
         st_d.hld = wr.hld_val;
      end
      if (kill_ack) begin
         st_d.kil = 1'b0;
      end else if (wr.kil_we) begin
         st_d.kil = wr.kil_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= st_d;
      end
   end

   assign st = st_q;

   // R6
   done_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !st.run);

   // R4
   ack_clears_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_ack |=> (!st.kil && !st.run));

   // R5
   stop_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st.stop |-> st.run);

   // R2
   run_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr.run_we && !done && !kill_ack && !parked) |=> $stable(st.run));

   // R3
   hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr.hld_we |=> (st.hld == $past(wr.hld_val)));

endmodule

// File: rtl/dma_chan_ctl_readback.sv
`timescale 1ns/1ps
module dma_chan_ctl_readback
   import dma_chan_ctl_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic              rd_miss,
   input  chan_st_t          st [NUM_CH],
   output logic [DATA_W-1:0] reg_rdata
);

   logic [DATA_W-1:0] image;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      image = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         image[RUN_LSB + c] = st[c].run;
         image[HLD_LSB + c] = st[c].hld;
         image[KIL_LSB + c] = st[c].kil;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_hit) begin
         rdata_q <= image;
      end else if (rd_miss) begin
         rdata_q <= '0;
      end
   end

   assign reg_rdata = rdata_q;

   // R7
   miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_miss |=> (reg_rdata == '0));

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hit && !rd_miss) |=> $stable(reg_rdata));

   // R7
   mask_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (reg_rdata[RUN_MSK_LSB +: SLOTS] == '0 &&
                  reg_rdata[HLD_MSK_LSB +: SLOTS] == '0));

endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl
   import dma_chan_ctl_pkg::*;
#(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 64,
   parameter logic [ADDR_W-1:0] REG_ADDR = 12'h018
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] eng_done,
   input  logic [NUM_CH-1:0] eng_parked,
   input  logic [NUM_CH-1:0] eng_kill_ack,
   output logic [NUM_CH-1:0] chan_run,
   output logic [NUM_CH-1:0] chan_hold,
   output logic [NUM_CH-1:0] chan_kill,
   output logic [NUM_CH-1:0] chan_stop_req
);

   if (NUM_CH < 1 || NUM_CH > SLOTS) begin : g_bad_ch
      $error("NUM_CH must lie in 1..8");
   end
   if (DATA_W < USED_BITS) begin : g_bad_w
      $error("DATA_W too narrow for the control word");
   end

   chan_wr_t wr_req [NUM_CH];
   chan_st_t st     [NUM_CH];
   logic     rd_hit;
   logic     rd_miss;

   dma_chan_ctl_decode #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) i_decode (
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .rd_hit    (rd_hit),
      .rd_miss   (rd_miss),
      .wr_req    (wr_req)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_chan_ctl_slice i_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_req[c]),
         .done     (eng_done[c]),
         .parked   (eng_parked[c]),
         .kill_ack (eng_kill_ack[c]),
         .st       (st[c])
      );
      assign chan_run[c]      = st[c].run;
      assign chan_hold[c]     = st[c].hld;
      assign chan_kill[c]     = st[c].kil;
      assign chan_stop_req[c] = st[c].stop;
   end

   dma_chan_ctl_readback #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) i_readback (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_hit    (rd_hit),
      .rd_miss   (rd_miss),
      .st        (st),
      .reg_rdata (reg_rdata)
   );

endmodule

// File: tb/test_dma_chan_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_ctl;

   localparam int unsigned NCH = 6;
   localparam logic [11:0] RADDR = 12'h018;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [11:0]       reg_addr = RADDR;
   logic [63:0]       reg_wdata = '0;
   logic [63:0]       reg_rdata;
   logic [NCH-1:0]    eng_done = '0;
   logic [NCH-1:0]    eng_parked = '0;
   logic [NCH-1:0]    eng_kill_ack = '0;
   logic [NCH-1:0]    chan_run, chan_hold, chan_kill, chan_stop_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dma_chan_ctl #(.NUM_CH(NCH), .REG_ADDR(RADDR)) i_dma_chan_ctl (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .eng_done, .eng_parked, .eng_kill_ack,
      .chan_run, .chan_hold, .chan_kill, .chan_stop_req
   );

   // write data, expected readback after it
   localparam logic [63:0] VW [0:7] = '{
      64'h0000_0000_0000_3F3F,  // R2 start ch0..5
      64'h0000_0000_0000_00FF,  // R2 no mask: ignored
      64'h0000_0000_0A0A_0000,  // R3 hold ch1, ch3
      64'h0000_0000_0200_0000,  // R3 resume ch1
      64'h0000_C0C0_C0C0_C0C0,  // R8 ch6/7 only
      64'h0000_0404_0000_0000,  // R4 kill ch2
      64'h0000_0000_0000_0100,  // R5 disable ch0 (pending)
      64'hFFFF_0000_0000_0000   // R7 high bits only
   };
   localparam logic [63:0] VE [0:7] = '{
      64'h0000_0000_0000_003F,
      64'h0000_0000_0000_003F,
      64'h0000_0000_000A_003F,
      64'h0000_0000_0008_003F,
      64'h0000_0000_0008_003F,
      64'h0000_0004_0008_003F,
      64'h0000_0004_0008_003F,
      64'h0000_0004_0008_003F
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; reg_addr = RADDR;
   endtask

   task automatic rd_reg(input logic [11:0] a);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0; reg_addr = RADDR;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 outputs", {40'd0, chan_run, chan_hold, chan_kill, chan_stop_req}, '0);
      rd_reg(RADDR);
      check("R1 readback", reg_rdata, '0);

      for (int i = 0; i < 8; i++) begin
         wr_reg(RADDR, VW[i]);
         rd_reg(RADDR);
         check($sformatf("R11 vector %0d", i), reg_rdata, VE[i]);
      end

      check("R2 run out", {58'd0, chan_run}, 64'h3F);
      check("R3 hold out", {58'd0, chan_hold}, 64'h08);
      check("R4 kill out", {58'd0, chan_kill}, 64'h04);
      check("R5 stop pending", {58'd0, chan_stop_req}, 64'h01);

      // R5 parked completes the disable
      @(negedge clk); eng_parked = 6'h01;
      @(negedge clk); eng_parked = '0;
      check("R5 run after park", {58'd0, chan_run}, 64'h3E);
      check("R5 stop after park", {58'd0, chan_stop_req}, 64'h00);

      // R5 parked on a channel without pending stop does nothing
      @(negedge clk); eng_parked = 6'h02;
      @(negedge clk); eng_parked = '0;
      check("R5 park no stop", {58'd0, chan_run}, 64'h3E);

      // R4 kill acknowledge
      @(negedge clk); eng_kill_ack = 6'h04;
      check("R4 kill before edge", {58'd0, chan_kill}, 64'h04);
      check("R4 run before edge", {58'd0, chan_run}, 64'h3E);
      @(negedge clk); eng_kill_ack = '0;
      check("R4 kill cleared", {58'd0, chan_kill}, 64'h00);
      check("R4 run cleared", {58'd0, chan_run}, 64'h3A);

      // R6 finished
      @(negedge clk); eng_done = 6'h10;
      @(negedge clk); eng_done = '0;
      check("R6 run after done", {58'd0, chan_run}, 64'h2A);

      // R10 done beats a same-edge start
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = 64'h0000_0000_0000_1010; eng_done = 6'h10;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; eng_done = '0;
      check("R10 done over write", {58'd0, chan_run}, 64'h2A);

      // R10 kill ack beats a same-edge kill write
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = 64'h0000_0808_0000_0000; eng_kill_ack = 6'h08;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; eng_kill_ack = '0;
      check("R10 ack over kill", {58'd0, chan_kill}, 64'h00);
      check("R10 ack clears run", {58'd0, chan_run}, 64'h22);

      // R5 disable on an idle channel has no effect
      wr_reg(RADDR, 64'h0000_0000_0000_0100);
      check("R5 idle disable", {58'd0, chan_stop_req}, 64'h00);

      // R5 re-enable withdraws pending stop
      wr_reg(RADDR, 64'h0000_0000_0000_2000);
      check("R5 stop raised", {58'd0, chan_stop_req}, 64'h20);
      wr_reg(RADDR, 64'h0000_0000_0000_2020);
      check("R5 stop withdrawn", {58'd0, chan_stop_req}, 64'h00);
      check("R5 still running", {58'd0, chan_run}, 64'h22);

      // R7 write and read at another address
      wr_reg(12'h020, 64'h0000_0101_0101_0101);
      check("R7 miss write", {40'd0, chan_run, chan_hold, chan_kill, chan_stop_req},
            {40'd0, 6'h22, 6'h08, 6'h00, 6'h00});
      rd_reg(12'h020);
      check("R7 miss read", reg_rdata, '0);

      // R9 read data holds without a read strobe
      rd_reg(RADDR);
      check("R9 read", reg_rdata, 64'h0000_0000_0008_0022);
      wr_reg(RADDR, 64'h0000_0000_0800_0000);
      repeat (2) @(negedge clk);
      check("R9 hold", reg_rdata, 64'h0000_0000_0008_0022);
      check("R3 resume out", {58'd0, chan_hold}, 64'h00);
      rd_reg(RADDR);
      check("R9 fresh read", reg_rdata, 64'h0000_0000_0000_0022);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule